// File: doc/BRIEF.md
# Configurable Dual-Port Memory Block

This block is a 256-bit memory with one write port and one read port. The two ports run from separate clocks. A static input picks the word shape: 64 words of 4 bits, or 32 words of 8 bits. Both shapes use the same storage. A byte at byte address b takes nibble 2b in data bits 3:0 and nibble 2b+1 in data bits 7:4. A design that needs small buffers uses the block as a building unit. It sets the shape once and then writes and reads it like any synchronous memory.

Each clock has a static polarity input. With the input low the port acts on the rising edge of its clock. With it high the port acts on the falling edge. Writes are synchronous. Reads are registered: the read data output loads on the active read edge and holds between reads. The active-low asynchronous reset clears the read data register only. The storage has no reset.

Top module: `dual_port_ram_cfg`

## Requirements
- R1: While rst_ni is low, rdata_o is 0 at once, with no clock edge needed.
- R2: In 4-bit mode (wide_i=0), a write stores wdata_i[3:0] at nibble waddr_i. A read returns nibble raddr_i on rdata_o[3:0] with rdata_o[7:4]=0.
- R3: In 8-bit mode (wide_i=1), waddr_i[5] and raddr_i[5] are ignored, and the byte address is bits 4:0.
- R4: In 8-bit mode, byte address b maps to nibble 2b (data bits 3:0) and nibble 2b+1 (data bits 7:4). Data written in one mode can be read in the other.
- R5: Storage changes only on an active write edge with we_i high.
- R6: rdata_o changes only on an active read edge with re_i high, and otherwise holds.
- R7: With wclk_inv_i=0 the write port acts on the rising edge of wclk_i. With wclk_inv_i=1 it acts on the falling edge.
- R8: With rclk_inv_i=0 the read port acts on the rising edge of rclk_i. With rclk_inv_i=1 it acts on the falling edge.
- R9: When a read and a write to the same location fall on the same active edge, the read returns the data held before that write.
- R10: Read data appears on rdata_o right after the active read edge that samples raddr_i, and not before that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst_ni | input | 1 | Active-low asynchronous reset of the read register |
| wide_i | input | 1 | Static shape select: 0 = 64x4, 1 = 32x8 |
| wclk_i | input | 1 | Write clock |
| wclk_inv_i | input | 1 | Write edge select: 0 = rising, 1 = falling |
| we_i | input | 1 | Write enable |
| waddr_i | input | 6 | Write address |
| wdata_i | input | 8 | Write data |
| rclk_i | input | 1 | Read clock |
| rclk_inv_i | input | 1 | Read edge select: 0 = rising, 1 = falling |
| re_i | input | 1 | Read enable |
| raddr_i | input | 6 | Read address |
| rdata_o | output | 8 | Registered read data |

## Verification
Both clocks share one bench clock, so the two ports have the same edges. The bench drives inputs 2 ns after a rising edge. For a falling edge port, the result is due at the next falling edge, 2 ns later. For a rising edge port, it is due at the following rising edge, 6 ns later. All results are sampled 2 ns after that rising edge. To tell the two polarities apart, the bench holds an enable high for only one half period, so the window covers either the falling edge or the rising edge. For R10 the bench samples rdata_o both before and after the rising edge of a read.

// File: rtl/dpram_pkg.sv
`timescale 1ns/1ps
package dpram_pkg;
  localparam int unsigned ADDR_W = 6;
  localparam int unsigned DATA_W = 8;
  localparam int unsigned NIB_W  = 4;

  typedef enum logic {
    ORG_NARROW = 1'b0,
    ORG_WIDE   = 1'b1
  } org_e;
endpackage

// File: rtl/dpram_clk_pol.sv
`timescale 1ns/1ps
module dpram_clk_pol (
  input  logic clk_i,
  input  logic inv_i,
  output logic clk_o
);
  // inv_i is static; inverting the clock moves the active edge to the falling one
  assign clk_o = clk_i ^ inv_i;
endmodule

// File: rtl/dpram_lane_map.sv
`timescale 1ns/1ps
module dpram_lane_map
  import dpram_pkg::*;
#(
  parameter int unsigned AW    = ADDR_W,
  parameter int unsigned LANES = DATA_W / NIB_W
) (
  input  org_e                       org_i,
  input  logic [AW-1:0]              addr_i,
  output logic [LANES-1:0][AW-1:0]   idx_o,
  output logic [LANES-1:0]           en_o
);
  localparam int unsigned LANE_AW = (LANES > 1) ? $clog2(LANES) : 1;

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    always_comb begin
      if (org_i == ORG_WIDE) begin
        // top address bits dropped, lane number fills the low bits
        idx_o[l] = {addr_i[AW-LANE_AW-1:0], LANE_AW'(l)};
        en_o[l]  = 1'b1;
      end else begin
        idx_o[l] = addr_i;
        en_o[l]  = (l == 0);
      end
    end
  end
endmodule

// File: rtl/dpram_store.sv
`timescale 1ns/1ps
module dpram_store
  import dpram_pkg::*;
#(
  parameter int unsigned AW    = ADDR_W,
  parameter int unsigned NW    = NIB_W,
  parameter int unsigned LANES = DATA_W / NIB_W
) (
  input  logic                     clk_i,
  input  logic                     we_i,
  input  logic [LANES-1:0][AW-1:0] idx_i,
  input  logic [LANES-1:0]         en_i,
  input  logic [LANES*NW-1:0]      wdata_i,
  output logic [(1<<AW)*NW-1:0]    mem_o
);
  localparam int unsigned DEPTH = 1 << AW;

  logic [NW-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    for (int l = 0; l < LANES; l++) begin
      if (we_i && en_i[l]) mem_q[idx_i[l]] <= wdata_i[l*NW +: NW];
    end
  end

  for (genvar d = 0; d < DEPTH; d++) begin : g_flat
    assign mem_o[d*NW +: NW] = mem_q[d];
  end
endmodule

// File: rtl/dpram_read.sv
`timescale 1ns/1ps
module dpram_read
  import dpram_pkg::*;
#(
  parameter int unsigned AW    = ADDR_W,
  parameter int unsigned NW    = NIB_W,
  parameter int unsigned LANES = DATA_W / NIB_W
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     re_i,
  input  logic [LANES-1:0][AW-1:0] idx_i,
  input  logic [LANES-1:0]         en_i,
  input  logic [(1<<AW)*NW-1:0]    mem_i,
  output logic [LANES*NW-1:0]      rdata_o
);
  logic [LANES*NW-1:0] rd_d;

  always_comb begin
    for (int l = 0; l < LANES; l++) begin
      rd_d[l*NW +: NW] = en_i[l] ? mem_i[idx_i[l]*NW +: NW] : '0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   rdata_o <= '0;
    else if (re_i) rdata_o <= rd_d;
  end
endmodule

// File: rtl/dual_port_ram_cfg.sv
`timescale 1ns/1ps
module dual_port_ram_cfg
  import dpram_pkg::*;
#(
  parameter int unsigned AW = ADDR_W,
  parameter int unsigned DW = DATA_W,
  parameter int unsigned NW = NIB_W
) (
  input  logic          rst_ni,
  input  logic          wide_i,
  input  logic          wclk_i,
  input  logic          wclk_inv_i,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          rclk_i,
  input  logic          rclk_inv_i,
  input  logic          re_i,
  input  logic [AW-1:0] raddr_i,
  output logic [DW-1:0] rdata_o
);
  localparam int unsigned LANES = DW / NW;
  localparam int unsigned BITS  = (1 << AW) * NW;

  org_e                     org;
  logic                     wclk_eff, rclk_eff;
  logic [LANES-1:0][AW-1:0] widx, ridx;
  logic [LANES-1:0]         wen, ren;
  logic [BITS-1:0]          mem_flat;

  assign org = org_e'(wide_i);

  dpram_clk_pol u_wpol (.clk_i(wclk_i), .inv_i(wclk_inv_i), .clk_o(wclk_eff));
  dpram_clk_pol u_rpol (.clk_i(rclk_i), .inv_i(rclk_inv_i), .clk_o(rclk_eff));

  dpram_lane_map #(.AW(AW), .LANES(LANES)) u_wmap (
    .org_i(org), .addr_i(waddr_i), .idx_o(widx), .en_o(wen)
  );
  dpram_lane_map #(.AW(AW), .LANES(LANES)) u_rmap (
    .org_i(org), .addr_i(raddr_i), .idx_o(ridx), .en_o(ren)
  );

  dpram_store #(.AW(AW), .NW(NW), .LANES(LANES)) u_store (
    .clk_i(wclk_eff), .we_i(we_i), .idx_i(widx), .en_i(wen),
    .wdata_i(wdata_i[LANES*NW-1:0]), .mem_o(mem_flat)
  );

  dpram_read #(.AW(AW), .NW(NW), .LANES(LANES)) u_read (
    .clk_i(rclk_eff), .rst_ni(rst_ni), .re_i(re_i), .idx_i(ridx),
    .en_i(ren), .mem_i(mem_flat), .rdata_o(rdata_o)
  );
endmodule

// File: rtl/dpram_sva.sv
`timescale 1ns/1ps
module dpram_sva #(
  parameter int unsigned DW = 8
) (
  input logic          rst_ni,
  input logic          wide_i,
  input logic          rclk_i,
  input logic          rclk_inv_i,
  input logic          re_i,
  input logic [DW-1:0] rdata_o
);
  logic rclk_chk;
  assign rclk_chk = rclk_i ^ rclk_inv_i;

  // R1: reset holds the read register at zero
  p_reset_zero_r1: assert property (@(posedge rclk_chk)
    !rst_ni |-> rdata_o == '0);

  // R6: no read enable, no change
  p_hold_idle_r6: assert property (@(posedge rclk_chk) disable iff (!rst_ni)
    !re_i |=> $stable(rdata_o));

  // R2: narrow read leaves upper half at zero
  p_upper_zero_r2: assert property (@(posedge rclk_chk) disable iff (!rst_ni)
    (re_i && !wide_i) |=> rdata_o[DW-1:DW/2] == '0);

  // R10: output moves only as a result of an enabled read edge
  p_change_needs_read_r10: assert property (@(posedge rclk_chk) disable iff (!rst_ni)
    !$stable(rdata_o) |-> $past(re_i));
endmodule

bind dual_port_ram_cfg dpram_sva #(.DW(DW)) u_sva (
  .rst_ni(rst_ni), .wide_i(wide_i), .rclk_i(rclk_i), .rclk_inv_i(rclk_inv_i),
  .re_i(re_i), .rdata_o(rdata_o)
);

// File: tb/sim_dual_port_ram_cfg.sv
`timescale 1ns/1ps
module sim_dual_port_ram_cfg;
  typedef struct packed {
    logic       wide;
    logic       we;
    logic [5:0] wa;
    logic [7:0] wd;
    logic       re;
    logic [5:0] ra;
    logic [7:0] exp;
    logic [3:0] req;
  } vec_t;

  localparam int NV = 11;
  localparam vec_t TBL [NV] = '{
    '{1'b0, 1'b1, 6'd5,  8'hA3, 1'b0, 6'd0,  8'h00, 4'd6},
    '{1'b0, 1'b1, 6'd6,  8'h0C, 1'b1, 6'd5,  8'h03, 4'd2},
    '{1'b1, 1'b1, 6'h22, 8'h7E, 1'b0, 6'd0,  8'h03, 4'd6},
    '{1'b1, 1'b1, 6'h03, 8'h5B, 1'b1, 6'h02, 8'h7E, 4'd3},
    '{1'b1, 1'b1, 6'h03, 8'h91, 1'b1, 6'h23, 8'h5B, 4'd9},
    '{1'b1, 1'b0, 6'h03, 8'hFF, 1'b1, 6'h03, 8'h91, 4'd5},
    '{1'b0, 1'b0, 6'd0,  8'h00, 1'b1, 6'd7,  8'h09, 4'd4},
    '{1'b0, 1'b1, 6'd4,  8'hF2, 1'b1, 6'd4,  8'h0E, 4'd9},
    '{1'b0, 1'b0, 6'd0,  8'h00, 1'b0, 6'd0,  8'h0E, 4'd6},
    '{1'b0, 1'b0, 6'd0,  8'h00, 1'b1, 6'd4,  8'h02, 4'd2},
    '{1'b1, 1'b0, 6'd0,  8'h00, 1'b1, 6'h22, 8'h72, 4'd3}
  };

  logic       clk = 1'b0;
  logic       rst_ni = 1'b1;
  logic       wide = 1'b0, wclk_inv = 1'b0, rclk_inv = 1'b0;
  logic       we = 1'b0, re = 1'b0;
  logic [5:0] waddr = '0, raddr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  int         checks = 0, errors = 0;
  bit         done = 1'b0;

  always #4 clk = ~clk;

  dual_port_ram_cfg u0 (
    .rst_ni(rst_ni), .wide_i(wide), .wclk_i(clk), .wclk_inv_i(wclk_inv),
    .we_i(we), .waddr_i(waddr), .wdata_i(wdata), .rclk_i(clk),
    .rclk_inv_i(rclk_inv), .re_i(re), .raddr_i(raddr), .rdata_o(rdata)
  );

  function automatic string req_name(input logic [3:0] r);
    case (r)
      4'd2: return "R2";
      4'd3: return "R3";
      4'd4: return "R4";
      4'd5: return "R5";
      4'd6: return "R6";
      4'd9: return "R9";
      default: return "R?";
    endcase
  endfunction

  task automatic check(input string req, input logic [7:0] exp);
    checks++;
    if (rdata !== exp) begin
      errors++;
      $display("FAIL %s: rdata=%h expected=%h at %0t", req, rdata, exp, $time);
    end
  endtask

  // Called 2 ns after a rising edge (T+2); returns at T+10.
  // win 0: enables T+2..T+10, 1: T+2..T+6 (falling edge), 2: T+6..T+10 (rising edge)
  task automatic op(input logic w, input logic [5:0] wa, input logic [7:0] wd,
                    input logic r, input logic [5:0] ra, input int win);
    waddr = wa; wdata = wd; raddr = ra;
    if (win != 2) begin we = w; re = r; end
    #4;
    if (win == 1) begin we = 1'b0; re = 1'b0; end
    if (win == 2) begin we = w; re = r; end
    #4;
    we = 1'b0; re = 1'b0;
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: run did not finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    #1 rst_ni = 1'b0;
    #2 check("R1", 8'h00);
    #20 rst_ni = 1'b1;
    @(posedge clk); #2;

    for (int i = 0; i < NV; i++) begin
      wide = TBL[i].wide;
      op(TBL[i].we, TBL[i].wa, TBL[i].wd, TBL[i].re, TBL[i].ra, 0);
      check(req_name(TBL[i].req), TBL[i].exp);
    end

    // R7: falling-edge write port
    wide = 1'b0;
    wclk_inv = 1'b1; op(0, 0, 0, 0, 0, 0);
    op(1, 6'd10, 8'h06, 0, 0, 1);
    op(1, 6'd11, 8'h01, 0, 0, 1);
    op(1, 6'd11, 8'h09, 0, 0, 2);
    wclk_inv = 1'b0; op(0, 0, 0, 0, 0, 0);
    op(0, 0, 0, 1, 6'd10, 0); check("R7", 8'h06);
    op(0, 0, 0, 1, 6'd11, 0); check("R7", 8'h01);

    // R8: falling-edge read port
    rclk_inv = 1'b1; op(0, 0, 0, 0, 0, 0);
    op(0, 0, 0, 1, 6'd10, 1); check("R8", 8'h06);
    op(0, 0, 0, 1, 6'd11, 2); check("R8", 8'h06);
    rclk_inv = 1'b0; op(0, 0, 0, 0, 0, 0);

    // R10: not before the edge, right after it
    raddr = 6'd4; re = 1'b1;
    #4 check("R10", 8'h06);
    #4 check("R10", 8'h02);
    re = 1'b0;

    // R1: asynchronous clear mid-run
    #1 rst_ni = 1'b0;
    #1 check("R1", 8'h00);
    #6 rst_ni = 1'b1;

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule